// File: doc/BRIEF.md
# BCD Clock Calendar Timekeeper

This block keeps the time of day and the calendar as packed binary-coded decimal bytes. A free-running enable pulse at 32.768 kHz drives a prescaler. The prescaler makes one tick per second. Each tick advances seconds, then minutes, then hours. A midnight rollover advances both the weekday and the date. The date rolls into the month and the month rolls into the year. A century flag toggles when the year passes from 99 to 00.

The eight bytes form a small register file. A serial or parallel bus front end can read any byte through a combinational read port and load any byte through a single-cycle write port. The byte order is fixed: seconds, minutes, century/hours, weekday, date, month, year, control. Both ports are plain strobed ports with no valid/ready handshake: a write is accepted in the cycle `wr_en` is high, and a read returns data in the same cycle it is addressed. This means there is no back-pressure to manage.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the bytes read seconds 0x00, minutes 0x00, century/hours 0x00, weekday 0x01, date 0x01, month 0x01, year 0x00, control 0x00.
- R2: The seconds byte advances by one every `PRESCALE` enable pulses. `tick_1hz` is high for exactly one clock: the clock in which the `PRESCALE`-th pulse is present.
- R3: Each byte holds BCD and keeps only its own bits. The masks are: seconds [6:0], minutes [6:0], hours [5:0] with the century flag at bit 7, weekday [2:0], date [5:0], month [4:0], year [7:0], and control bit 7 only. Every other bit reads 0 whatever was written.
- R4: Seconds and minutes each roll over from 0x59 to 0x00 and carry one into the next byte in the same tick.
- R5: Hours roll over from 0x23 to 0x00. This rollover advances the weekday and the date in the same tick.
- R6: The weekday counts 0x01 to 0x07 and returns to 0x01 after 0x07, whatever the date.
- R7: The date rolls back to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months except February. Each date rollover advances the month, and a rollover from month 0x12 to 0x01 advances the year.
- R8: When the year, read as a decimal number, is divisible by four, February ends at 0x29; otherwise it ends at 0x28.
- R9: When the year rolls over from 0x99 to 0x00, the century flag (hours byte bit 7) inverts.
- R10: A write to the seconds byte (offset 0) clears the prescaler. The next tick therefore comes exactly `PRESCALE` pulses after the write.
- R11: While control bit 7 is set, the prescaler neither counts nor ticks, and it keeps its partial count. Once the bit is cleared, counting resumes from that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-clock enable pulse at 32.768 kHz |
| wr_en | input | 1 | Write strobe for the register file |
| wr_addr | input | 3 | Byte offset to write |
| wr_data | input | 8 | Byte to write |
| rd_addr | input | 3 | Byte offset to read |
| rd_data | output | 8 | Byte at `rd_addr`, combinational |
| tick_1hz | output | 1 | One-clock pulse at each second advance |

## Verification
The bench builds the block with `PRESCALE` set to 4 instead of 32768, so each second costs four enable pulses. This puts every cascade in reach within a few hundred clocks: minute, hour, midnight, month end, leap February and the century flip. It also makes the prescaler clear and freeze behaviour visible pulse by pulse, because a partial count of two pulses can be held across a stop and then finished.

// File: rtl/bcd_tk_pkg.sv
package bcd_tk_pkg;
  typedef enum logic [2:0] {
    OFS_SEC   = 3'd0,
    OFS_MIN   = 3'd1,
    OFS_HOUR  = 3'd2,
    OFS_WDAY  = 3'd3,
    OFS_DATE  = 3'd4,
    OFS_MONTH = 3'd5,
    OFS_YEAR  = 3'd6,
    OFS_CTRL  = 3'd7
  } tk_ofs_e;

  localparam int unsigned TOD_FIELDS = 3;

  // Add one to a packed BCD byte (low digit wraps into the high digit).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Decimal year divisible by four: (10*hi + lo) mod 4 == (2*hi + lo) mod 4.
  function automatic logic leap_year(input logic [7:0] yr);
    logic [1:0] s;
    s = {yr[4], 1'b0} + yr[1:0];
    return (s == 2'd0);
  endfunction

  // Last date of a month, in BCD.
  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] r;
    case (mon)
      8'h02:                      r = leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

  // Bits each byte keeps on a write.
  function automatic logic [7:0] keep_mask(input logic [2:0] ofs);
    logic [7:0] m;
    case (ofs)
      OFS_SEC, OFS_MIN: m = 8'h7F;
      OFS_HOUR:         m = 8'h3F;
      OFS_WDAY:         m = 8'h07;
      OFS_DATE:         m = 8'h3F;
      OFS_MONTH:        m = 8'h1F;
      OFS_YEAR:         m = 8'hFF;
      default:          m = 8'h80;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/bcd_tk_prescaler.sv
module bcd_tk_prescaler #(
  parameter int unsigned DIV = 32768,
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clr_i,
  input  logic stop_i,
  output logic tick_o
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && !stop_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (en_i && !stop_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0);

  // R11
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !clr_i) |=> $stable(cnt_q));

  // R2
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> cnt_q == '0);
endmodule

// File: rtl/bcd_tk_field.sv
module bcd_tk_field #(
  parameter logic [7:0] MIN_V = 8'h00,
  parameter logic [7:0] RST_V = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       adv_i,
  input  logic [7:0] max_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);
  import bcd_tk_pkg::*;

  logic [7:0] val_q;

  assign val_o  = val_q;
  assign wrap_o = adv_i && !load_i && (val_q == max_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= RST_V;
    else if (load_i) val_q <= load_val_i;
    else if (adv_i)  val_q <= (val_q == max_i) ? MIN_V : bcd_inc(val_q);
  end

  // R4
  field_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && val_q == max_i) |=> val_q == MIN_V);

  // R3
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(val_q));
endmodule

// File: rtl/bcd_tk_calendar.sv
module bcd_tk_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv_i,
  input  logic       ld_wday_i,
  input  logic       ld_date_i,
  input  logic       ld_month_i,
  input  logic       ld_year_i,
  input  logic       ld_cent_i,
  input  logic       cent_val_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       cent_o
);
  import bcd_tk_pkg::*;

  logic       wday_wrap, date_wrap, month_wrap, year_wrap;
  logic [7:0] date_max;
  logic       cent_q;

  assign date_max = last_date(month_o, year_o);
  assign cent_o   = cent_q;

  bcd_tk_field #(.MIN_V(8'h01), .RST_V(8'h01)) u_wday (
    .clk(clk), .rst_n(rst_n), .load_i(ld_wday_i), .load_val_i(ld_val_i),
    .adv_i(adv_i), .max_i(8'h07), .val_o(wday_o), .wrap_o(wday_wrap));

  bcd_tk_field #(.MIN_V(8'h01), .RST_V(8'h01)) u_date (
    .clk(clk), .rst_n(rst_n), .load_i(ld_date_i), .load_val_i(ld_val_i),
    .adv_i(adv_i), .max_i(date_max), .val_o(date_o), .wrap_o(date_wrap));

  bcd_tk_field #(.MIN_V(8'h01), .RST_V(8'h01)) u_month (
    .clk(clk), .rst_n(rst_n), .load_i(ld_month_i), .load_val_i(ld_val_i),
    .adv_i(date_wrap), .max_i(8'h12), .val_o(month_o), .wrap_o(month_wrap));

  bcd_tk_field #(.MIN_V(8'h00), .RST_V(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .load_i(ld_year_i), .load_val_i(ld_val_i),
    .adv_i(month_wrap), .max_i(8'h99), .val_o(year_o), .wrap_o(year_wrap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cent_q <= 1'b0;
    else if (ld_cent_i) cent_q <= cent_val_i;
    else if (year_wrap) cent_q <= ~cent_q;
  end

  // R9
  cent_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (year_wrap && !ld_cent_i) |=> (cent_q != $past(cent_q)) && (year_o == 8'h00));

  // R7
  month_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (date_wrap && !ld_month_i) |=> (date_o == 8'h01) && (month_o != $past(month_o)));

  // R6
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wday_wrap && !ld_wday_i) |=> wday_o == 8'h01);
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper #(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       tick_1hz
);
  import bcd_tk_pkg::*;

  localparam logic [7:0] TOD_MAX [TOD_FIELDS] = '{8'h59, 8'h59, 8'h23};

  logic       stop_q;
  logic       sec_clr;
  logic       tick;
  logic [7:0] wr_kept;
  logic [7:0] tod_val [TOD_FIELDS];
  logic       tod_adv [TOD_FIELDS+1];
  logic [7:0] wday, date, month, year;
  logic       cent;

  assign wr_kept  = wr_data & keep_mask(wr_addr);
  assign sec_clr  = wr_en && (wr_addr == OFS_SEC);
  assign tick_1hz = tick;
  // A write cycle takes precedence over a coinciding tick.
  assign tod_adv[0] = tick && !wr_en;

  bcd_tk_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n), .en_i(osc_en), .clr_i(sec_clr),
    .stop_i(stop_q), .tick_o(tick));

  for (genvar g = 0; g < TOD_FIELDS; g++) begin : g_tod
    logic ld;
    assign ld = wr_en && (wr_addr == 3'(g));
    bcd_tk_field #(.MIN_V(8'h00), .RST_V(8'h00)) u_fld (
      .clk(clk), .rst_n(rst_n), .load_i(ld), .load_val_i(wr_kept),
      .adv_i(tod_adv[g]), .max_i(TOD_MAX[g]), .val_o(tod_val[g]),
      .wrap_o(tod_adv[g+1]));
  end

  bcd_tk_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .adv_i(tod_adv[TOD_FIELDS]),
    .ld_wday_i (wr_en && (wr_addr == OFS_WDAY)),
    .ld_date_i (wr_en && (wr_addr == OFS_DATE)),
    .ld_month_i(wr_en && (wr_addr == OFS_MONTH)),
    .ld_year_i (wr_en && (wr_addr == OFS_YEAR)),
    .ld_cent_i (wr_en && (wr_addr == OFS_HOUR)),
    .cent_val_i(wr_data[7]), .ld_val_i(wr_kept),
    .wday_o(wday), .date_o(date), .month_o(month), .year_o(year), .cent_o(cent));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              stop_q <= 1'b0;
    else if (wr_en && wr_addr == OFS_CTRL)   stop_q <= wr_data[7];
  end

  always_comb begin
    case (rd_addr)
      OFS_SEC:   rd_data = tod_val[0];
      OFS_MIN:   rd_data = tod_val[1];
      OFS_HOUR:  rd_data = {cent, 1'b0, tod_val[2][5:0]};
      OFS_WDAY:  rd_data = wday;
      OFS_DATE:  rd_data = date;
      OFS_MONTH: rd_data = month;
      OFS_YEAR:  rd_data = year;
      default:   rd_data = {stop_q, 7'd0};
    endcase
  end

  // R11
  stop_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !tick_1hz);

  // R5
  midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_adv[2] && !wr_en && tod_val[2] == 8'h23) |=> (tod_val[2] == 8'h00) && (date != $past(date)));
endmodule

// File: tb/bcd_timekeeper_test.sv
module bcd_timekeeper_test;
  localparam int unsigned PS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tick_1hz;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bcd_timekeeper #(.PRESCALE(PS)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .tick_1hz(tick_1hz));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic pulses(input int n, output int ticks);
    ticks = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_en = 1'b1;
      #1 if (tick_1hz) ticks++;
      @(negedge clk); osc_en = 1'b0;
    end
  endtask

  // Loads all fields; seconds last so the prescaler starts clean.
  task automatic set_all(input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se,
                         input logic [7:0] wd, input logic [7:0] dt, input logic [7:0] mo,
                         input logic [7:0] yr);
    wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, wd);
    wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
  endtask

  task automatic one_second();
    int t;
    pulses(PS, t);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    logic [7:0] exp [8] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R1 reset value", v, exp[a]);
    end
  endtask

  task automatic t_prescale();
    logic [7:0] v; int t;
    wr(3'd0, 8'h10);
    pulses(PS - 1, t);
    rd(3'd0, v); chk("R10 no advance before full count", v, 8'h10);
    chk("R2 no tick early", 8'(t), 8'd0);
    pulses(1, t);
    chk("R2 one tick on last pulse", 8'(t), 8'd1);
    rd(3'd0, v); chk("R2 seconds advanced", v, 8'h11);
    pulses(2, t);
    wr(3'd0, 8'h20);
    pulses(PS - 1, t);
    rd(3'd0, v); chk("R10 write clears partial count", v, 8'h20);
    pulses(1, t);
    rd(3'd0, v); chk("R10 tick a full second after write", v, 8'h21);
  endtask

  task automatic t_minute_hour();
    logic [7:0] v;
    set_all(8'h05, 8'h59, 8'h59, 8'h02, 8'h10, 8'h06, 8'h24);
    one_second();
    rd(3'd0, v); chk("R4 seconds 59 to 00", v, 8'h00);
    rd(3'd1, v); chk("R4 minutes 59 to 00", v, 8'h00);
    rd(3'd2, v); chk("R4 carry into hours", v, 8'h06);
    set_all(8'h13, 8'h19, 8'h09, 8'h02, 8'h10, 8'h06, 8'h24);
    one_second();
    rd(3'd0, v); chk("R4 BCD digit carry", v, 8'h10);
    rd(3'd1, v); chk("R4 minutes untouched", v, 8'h19);
  endtask

  task automatic t_midnight();
    logic [7:0] v;
    set_all(8'h23, 8'h59, 8'h59, 8'h07, 8'h15, 8'h03, 8'h24);
    one_second();
    rd(3'd2, v); chk("R5 hours 23 to 00", v, 8'h00);
    rd(3'd3, v); chk("R6 weekday 7 to 1", v, 8'h01);
    rd(3'd4, v); chk("R5 date advanced", v, 8'h16);
    set_all(8'h23, 8'h59, 8'h59, 8'h03, 8'h31, 8'h05, 8'h24);
    one_second();
    rd(3'd3, v); chk("R6 weekday independent of date", v, 8'h04);
    rd(3'd4, v); chk("R7 date 31 to 01", v, 8'h01);
    rd(3'd5, v); chk("R7 month 05 to 06", v, 8'h06);
  endtask

  task automatic month_end(input string req, input logic [7:0] dt, input logic [7:0] mo,
                           input logic [7:0] yr, input logic [7:0] edt, input logic [7:0] emo);
    logic [7:0] v;
    set_all(8'h23, 8'h59, 8'h59, 8'h01, dt, mo, yr);
    one_second();
    rd(3'd4, v); chk(req, v, edt);
    rd(3'd5, v); chk(req, v, emo);
  endtask

  task automatic t_months();
    month_end("R7 thirty-day month", 8'h30, 8'h04, 8'h23, 8'h01, 8'h05);
    month_end("R7 thirty-day month mid", 8'h30, 8'h01, 8'h23, 8'h31, 8'h01);
    month_end("R7 november end", 8'h30, 8'h11, 8'h23, 8'h01, 8'h12);
    month_end("R8 non-leap february", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
    month_end("R8 leap february 28", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
    month_end("R8 leap february 29", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
    month_end("R8 year 00 is leap", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
    month_end("R8 year 12 is leap", 8'h28, 8'h02, 8'h12, 8'h29, 8'h02);
    month_end("R8 year 10 not leap", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03);
  endtask

  task automatic t_century();
    logic [7:0] v;
    set_all(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
    one_second();
    rd(3'd6, v); chk("R7 year 99 to 00", v, 8'h00);
    rd(3'd5, v); chk("R7 month 12 to 01", v, 8'h01);
    rd(3'd2, v); chk("R9 century set", v, 8'h80);
    set_all(8'hA3, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
    one_second();
    rd(3'd2, v); chk("R9 century cleared", v, 8'h00);
    set_all(8'hA3, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h98);
    one_second();
    rd(3'd2, v); chk("R9 century kept", v, 8'h80);
    rd(3'd6, v); chk("R7 year 98 to 99", v, 8'h99);
  endtask

  task automatic t_masks();
    logic [7:0] v;
    wr(3'd0, 8'hFF); rd(3'd0, v); chk("R3 seconds mask", v, 8'h7F);
    wr(3'd3, 8'hFF); rd(3'd3, v); chk("R3 weekday mask", v, 8'h07);
    wr(3'd2, 8'hFF); rd(3'd2, v); chk("R3 hours mask", v, 8'hBF);
    wr(3'd5, 8'hFF); rd(3'd5, v); chk("R3 month mask", v, 8'h1F);
    wr(3'd7, 8'hFF); rd(3'd7, v); chk("R3 control mask", v, 8'h80);
    wr(3'd7, 8'h00); rd(3'd7, v); chk("R3 control cleared", v, 8'h00);
  endtask

  task automatic t_stop();
    logic [7:0] v; int t;
    wr(3'd0, 8'h30);
    pulses(2, t);
    wr(3'd7, 8'h80);
    pulses(3 * PS, t);
    chk("R11 no tick while stopped", 8'(t), 8'd0);
    rd(3'd0, v); chk("R11 seconds frozen", v, 8'h30);
    wr(3'd7, 8'h00);
    pulses(PS - 3, t);
    rd(3'd0, v); chk("R11 count kept, not yet", v, 8'h30);
    pulses(1, t);
    chk("R11 tick resumes from held count", 8'(t), 8'd1);
    rd(3'd0, v); chk("R11 seconds advance after resume", v, 8'h31);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_minute_hour();
    t_midnight();
    t_months();
    t_century();
    t_masks();
    t_stop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule